// File: doc/BRIEF.md
# Descriptor-Driven Scatter-Gather Walker

This block moves a requested number of bytes between a local sector buffer and scattered regions of system memory. The regions are listed in a table of 8-byte descriptors in memory. Each descriptor gives a region's base address and a control word that carries its byte count and an end-of-table flag. The walker fetches descriptors one at a time over a single request/response memory port. It keeps the active region's address and remaining length in a small cache. It then issues one burst request per chunk, and each burst either reads memory into the buffer or writes the buffer out to memory.

A controller points the walker at a table base. It pulses `rewind` to reload the descriptor pointer and `arm` to drop any cached region. It then pulses `go` with a byte count and a direction. The transfer ends with a one-cycle `done` pulse. When `done_ok` is 1, the full count was moved. When it is 0, the table ran out first: either the final descriptor was used up, or the pointer had moved a full 4 KiB past the base. A leftover cached region carries over to the next `go` unless `arm` clears it, so one long transfer can be split into several calls.

Top module: `prd_walker`

## Requirements
- R1: A synchronous reset returns the walker to idle with no request and no `done`. It zeroes the descriptor pointer and clears the cached region, so the first `go` after reset fetches a descriptor from address 0.
- R2: A descriptor fetch is a request with `mem_req_desc`=1, `mem_req_write`=0, `mem_req_len`=8 and `mem_req_addr` equal to the descriptor pointer. The pointer advances by 8 on each accepted fetch. `rewind` while idle loads the pointer from `tbl_base`.
- R3: The fetched 64-bit word is little-endian. Bits 31:0 are the region address and bits 63:32 are the control word. The region length is control bits 15:1 times two, with bit 0 and bits 30:16 ignored. A zero field means 65536 bytes.
- R4: Each data request has length min(bytes still to move, bytes left in region). After each request the region address and `mem_req_bufidx` both advance by that length, and `mem_req_bufidx` starts at 0 on every `go`.
- R5: Control bit 31 marks the final descriptor. Once that region is used up with bytes still owed, no further fetch happens and `done` rises with `done_ok`=0.
- R6: When the region is empty and the pointer is 4096 or more bytes past `tbl_base`, no fetch is issued and `done` rises with `done_ok`=0.
- R7: When the requested count has been moved, `done` pulses for one cycle with `done_ok`=1. A count of 0 completes with no memory request.
- R8: `mem_req_write` on data requests equals the `go_to_mem` value captured at `go` (1 = buffer to memory, 0 = memory to buffer).
- R9: At most one request is outstanding. A request stays valid and unchanged until accepted, and no new request appears before `mem_rsp_valid` answers the previous one.
- R10: `arm` while idle discards the cached region, so the next step fetches a new descriptor. Without `arm`, a following `go` continues in the leftover region with no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 32 | Descriptor table base address |
| rewind | input | 1 | Reload descriptor pointer from `tbl_base` (idle only) |
| arm | input | 1 | Discard cached region (idle only) |
| go | input | 1 | Start a transfer (idle only) |
| go_bytes | input | CNT_W | Byte count for the transfer |
| go_to_mem | input | 1 | Direction: 1 writes memory, 0 reads memory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_desc | output | 1 | Request is a descriptor fetch |
| mem_req_write | output | 1 | Request writes memory |
| mem_req_addr | output | 32 | Byte address |
| mem_req_len | output | 17 | Byte length |
| mem_req_bufidx | output | CNT_W | Local buffer offset for data requests |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_data | input | 64 | Descriptor contents on fetch responses |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_ok | output | 1 | 1 = count met, 0 = table exhausted |

## Verification
The hardest case to reach is the 4 KiB safeguard. It only trips after 512 consecutive fetches of descriptors that have no end flag. The bench fills a table region with 2-byte descriptors and requests 1026 bytes, which needs more than the 512 descriptors allow. It also requests exactly 1024 bytes, which completes just as the pointer reaches the boundary. A second hard case is a region that spans calls: the bench splits a transfer over two `go` pulses without `arm`, and then with `arm`, to show the cache either persists or is dropped. The sweeps stall the request handshake on every third cycle, so request holding is exercised throughout.

// File: rtl/prd_pkg.sv
package prd_pkg;

    localparam int PRD_AW     = 32;
    localparam int PRD_LW     = 17;
    localparam int DESC_BYTES = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FREQ,
        S_FWAIT,
        S_DREQ,
        S_DWAIT
    } walk_state_e;

    typedef struct packed {
        logic [PRD_AW-1:0] addr;
        logic [PRD_LW-1:0] len;
        logic              last;
    } region_t;

    // Length field: bits 15:1 of the control word, zero meaning 64 KiB.
    function automatic logic [PRD_LW-1:0] prd_len(input logic [31:0] ctl);
        logic [14:0] field;
        field = ctl[15:1];
        if (field == '0)
            return 17'h1_0000;
        return {1'b0, field, 1'b0};
    endfunction

    function automatic region_t prd_decode(input logic [63:0] raw);
        region_t r;
        r.addr = raw[31:0];
        r.len  = prd_len(raw[63:32]);
        r.last = raw[63];
        return r;
    endfunction

endpackage

// File: rtl/prd_region.sv
module prd_region
    import prd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [63:0]       load_raw,
    input  logic              consume,
    input  logic [PRD_LW-1:0] consume_n,
    output region_t           region
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            region <= '0;
        end else if (load) begin
            region <= prd_decode(load_raw);
        end else if (consume) begin
            region.addr <= region.addr + PRD_AW'(consume_n);
            region.len  <= region.len - consume_n;
        end
    end

endmodule

// File: rtl/prd_ptr.sv
module prd_ptr
    import prd_pkg::*;
#(
    parameter int GUARD_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewind,
    input  logic [PRD_AW-1:0] base,
    input  logic              step,
    output logic [PRD_AW-1:0] ptr,
    output logic              guard_hit
);

    localparam logic [PRD_AW-1:0] GUARD = PRD_AW'(GUARD_BYTES);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (rewind)
            ptr <= base;
        else if (step)
            ptr <= ptr + PRD_AW'(DESC_BYTES);
    end

    assign guard_hit = (ptr - base) >= GUARD;

endmodule

// File: rtl/prd_ctrl.sv
module prd_ctrl
    import prd_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_bytes,
    input  logic              go_to_mem,
    input  region_t           region,
    input  logic              guard_hit,
    input  logic [PRD_AW-1:0] ptr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic              req_desc,
    output logic              req_write,
    output logic [PRD_AW-1:0] req_addr,
    output logic [PRD_LW-1:0] req_len,
    output logic [CNT_W-1:0]  req_bufidx,
    output logic              ptr_step,
    output logic              cache_load,
    output logic              cache_consume,
    output logic [PRD_LW-1:0] chunk,
    output logic              idle,
    output logic              done,
    output logic              done_ok
);

    walk_state_e state;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] bidx;
    logic             dir;

    always_comb begin
        if (rem < CNT_W'(region.len))
            chunk = PRD_LW'(rem);
        else
            chunk = region.len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            rem     <= '0;
            bidx    <= '0;
            dir     <= 1'b0;
            done    <= 1'b0;
            done_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (go) begin
                    rem   <= go_bytes;
                    bidx  <= '0;
                    dir   <= go_to_mem;
                    state <= S_CHECK;
                end
                S_CHECK: begin
                    if (rem == '0) begin
                        done    <= 1'b1;
                        done_ok <= 1'b1;
                        state   <= S_IDLE;
                    end else if (region.len == '0) begin
                        if (region.last || guard_hit) begin
                            done    <= 1'b1;
                            done_ok <= 1'b0;
                            state   <= S_IDLE;
                        end else begin
                            state <= S_FREQ;
                        end
                    end else begin
                        state <= S_DREQ;
                    end
                end
                S_FREQ:  if (req_ready) state <= S_FWAIT;
                S_FWAIT: if (rsp_valid) state <= S_CHECK;
                S_DREQ:  if (req_ready) state <= S_DWAIT;
                S_DWAIT: if (rsp_valid) begin
                    rem   <= rem - CNT_W'(chunk);
                    bidx  <= bidx + CNT_W'(chunk);
                    state <= S_CHECK;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_valid     = (state == S_FREQ) || (state == S_DREQ);
    assign req_desc      = (state == S_FREQ);
    assign req_write     = (state == S_DREQ) && dir;
    assign req_addr      = (state == S_FREQ) ? ptr : region.addr;
    assign req_len       = (state == S_FREQ) ? PRD_LW'(DESC_BYTES) : chunk;
    assign req_bufidx    = bidx;
    assign ptr_step      = (state == S_FREQ) && req_ready;
    assign cache_load    = (state == S_FWAIT) && rsp_valid;
    assign cache_consume = (state == S_DWAIT) && rsp_valid;
    assign idle          = (state == S_IDLE);

endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int GUARD_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       tbl_base,
    input  logic              rewind,
    input  logic              arm,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_bytes,
    input  logic              go_to_mem,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_desc,
    output logic              mem_req_write,
    output logic [31:0]       mem_req_addr,
    output logic [16:0]       mem_req_len,
    output logic [CNT_W-1:0]  mem_req_bufidx,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              done,
    output logic              done_ok
);

    region_t           region;
    logic [PRD_AW-1:0] ptr;
    logic              guard_hit;
    logic              ptr_step;
    logic              cache_load;
    logic              cache_consume;
    logic [PRD_LW-1:0] chunk;
    logic              idle;

    prd_ptr #(.GUARD_BYTES(GUARD_BYTES)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .rewind    (rewind && idle),
        .base      (tbl_base),
        .step      (ptr_step),
        .ptr       (ptr),
        .guard_hit (guard_hit)
    );

    prd_region u_region (
        .clk       (clk),
        .rst       (rst),
        .clear     (arm && idle),
        .load      (cache_load),
        .load_raw  (mem_rsp_data),
        .consume   (cache_consume),
        .consume_n (chunk),
        .region    (region)
    );

    prd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .go_bytes      (go_bytes),
        .go_to_mem     (go_to_mem),
        .region        (region),
        .guard_hit     (guard_hit),
        .ptr           (ptr),
        .req_ready     (mem_req_ready),
        .rsp_valid     (mem_rsp_valid),
        .req_valid     (mem_req_valid),
        .req_desc      (mem_req_desc),
        .req_write     (mem_req_write),
        .req_addr      (mem_req_addr),
        .req_len       (mem_req_len),
        .req_bufidx    (mem_req_bufidx),
        .ptr_step      (ptr_step),
        .cache_load    (cache_load),
        .cache_consume (cache_consume),
        .chunk         (chunk),
        .idle          (idle),
        .done          (done),
        .done_ok       (done_ok)
    );

endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
    parameter int CNT_W       = 24,
    parameter int GUARD_BYTES = 4096
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      tbl_base,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_desc,
    input logic             mem_req_write,
    input logic [31:0]      mem_req_addr,
    input logic [16:0]      mem_req_len,
    input logic [CNT_W-1:0] mem_req_bufidx,
    input logic             mem_rsp_valid,
    input logic             done
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready)
            outstanding <= 1'b1;
        else if (mem_rsp_valid)
            outstanding <= 1'b0;
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req_valid && !done));

    p_desc_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_desc) |-> (mem_req_len == 17'd8 && !mem_req_write));

    p_chunk_range_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_desc) |-> (mem_req_len != 17'd0 && mem_req_len <= 17'h1_0000));

    p_guard_window_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_desc) |-> ((mem_req_addr - tbl_base) < 32'(GUARD_BYTES)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)
             && $stable(mem_req_desc) && $stable(mem_req_write) && $stable(mem_req_bufidx)));

    p_single_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !mem_req_valid);

endmodule

bind prd_walker prd_walker_chk #(.CNT_W(CNT_W), .GUARD_BYTES(GUARD_BYTES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tbl_base       (tbl_base),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_desc   (mem_req_desc),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_len    (mem_req_len),
    .mem_req_bufidx (mem_req_bufidx),
    .mem_rsp_valid  (mem_rsp_valid),
    .done           (done)
);

// File: tb/tb_prd_walker.sv
module tb_prd_walker;

    localparam int CNT_W = 24;
    localparam int LOGN  = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0]      tbl_base = '0;
    logic             rewind = 1'b0, arm = 1'b0, go = 1'b0, go_to_mem = 1'b0;
    logic [CNT_W-1:0] go_bytes = '0;
    logic             mem_req_valid, mem_req_desc, mem_req_write;
    logic             mem_req_ready = 1'b0;
    logic [31:0]      mem_req_addr;
    logic [16:0]      mem_req_len;
    logic [CNT_W-1:0] mem_req_bufidx;
    logic             mem_rsp_valid = 1'b0;
    logic [63:0]      mem_rsp_data = '0;
    logic             done, done_ok;

    prd_walker #(.CNT_W(CNT_W), .GUARD_BYTES(4096)) dut (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .rewind(rewind), .arm(arm),
        .go(go), .go_bytes(go_bytes), .go_to_mem(go_to_mem),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_desc(mem_req_desc), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_req_bufidx(mem_req_bufidx), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_ok(done_ok)
    );

    int tests = 0;
    int fails = 0;

    // descriptor memory, indexed by address / 8
    logic [31:0] tbl_addr [1024];
    logic [31:0] tbl_ctl  [1024];

    // observed request log
    logic        lg_desc [LOGN];
    logic        lg_wr   [LOGN];
    logic [31:0] lg_addr [LOGN];
    logic [16:0] lg_len  [LOGN];
    int          lg_idx  [LOGN];
    int          lg_n;

    // expected request log
    logic        ex_desc [LOGN];
    logic        ex_wr   [LOGN];
    logic [31:0] ex_addr [LOGN];
    logic [16:0] ex_len  [LOGN];
    int          ex_idx  [LOGN];
    int          ex_n;
    logic        ex_ok;

    // reference state
    logic [31:0] m_ptr, m_raddr;
    int          m_rlen;
    logic        m_last;

    // memory responder
    int          cyc = 0;
    int          lat = 0;
    logic        pend_desc = 1'b0;
    logic [31:0] pend_addr = '0;

    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rst) begin
            lat = 0;
            mem_req_ready = 1'b0;
        end else begin
            if (lat != 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_desc ?
                        {tbl_ctl[(pend_addr >> 3) & 1023], tbl_addr[(pend_addr >> 3) & 1023]} : 64'd0;
                end
            end
            mem_req_ready = (cyc % 3) != 1;
            if (mem_req_valid && mem_req_ready) begin
                if (lg_n < LOGN) begin
                    lg_desc[lg_n] = mem_req_desc;
                    lg_wr[lg_n]   = mem_req_write;
                    lg_addr[lg_n] = mem_req_addr;
                    lg_len[lg_n]  = mem_req_len;
                    lg_idx[lg_n]  = int'(mem_req_bufidx);
                end
                lg_n++;
                pend_desc = mem_req_desc;
                pend_addr = mem_req_addr;
                lat = 2;
            end
        end
    end

    task automatic check(input bit cond, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic ex_push(input logic d, input logic w, input logic [31:0] a,
                           input int l, input int bi);
        ex_desc[ex_n] = d; ex_wr[ex_n] = w; ex_addr[ex_n] = a;
        ex_len[ex_n] = 17'(l); ex_idx[ex_n] = bi;
        ex_n++;
    endtask

    task automatic model(input int bytes, input logic dir);
        int rem, bi, ch, f;
        logic [31:0] c;
        rem = bytes; bi = 0; ex_n = 0;
        forever begin
            if (rem == 0) begin ex_ok = 1'b1; break; end
            if (m_rlen == 0) begin
                if (m_last || ((m_ptr - tbl_base) >= 32'd4096)) begin ex_ok = 1'b0; break; end
                ex_push(1'b1, 1'b0, m_ptr, 8, bi);
                c = tbl_ctl[(m_ptr >> 3) & 1023];
                m_raddr = tbl_addr[(m_ptr >> 3) & 1023];
                f = int'(c[15:1]);
                m_rlen = (f == 0) ? 65536 : f * 2;
                m_last = c[31];
                m_ptr = m_ptr + 8;
            end
            ch = (rem < m_rlen) ? rem : m_rlen;
            ex_push(1'b0, dir, m_raddr, ch, bi);
            m_raddr = m_raddr + 32'(ch);
            m_rlen -= ch; rem -= ch; bi += ch;
        end
    endtask

    task automatic do_rewind_arm();
        @(negedge clk); rewind = 1'b1; arm = 1'b1;
        @(negedge clk); rewind = 1'b0; arm = 1'b0;
        m_ptr = tbl_base; m_rlen = 0; m_last = 1'b0; m_raddr = '0;
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        m_rlen = 0; m_last = 1'b0; m_raddr = '0;
    endtask

    task automatic run(input int bytes, input logic dir, input string tag_log,
                       input string tag_ok);
        int   w;
        logic got_ok;
        bit   same;
        model(bytes, dir);
        @(negedge clk);
        lg_n = 0;
        go = 1'b1; go_bytes = CNT_W'(bytes); go_to_mem = dir;
        @(negedge clk);
        go = 1'b0;
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        got_ok = done_ok;
        check(done === 1'b1, tag_ok, "done seen", done, 1);
        check(lg_n == ex_n, tag_log, "request count", lg_n, ex_n);
        same = 1'b1;
        for (int i = 0; i < ex_n && i < lg_n && i < LOGN; i++) begin
            if (same && (lg_desc[i] !== ex_desc[i] || lg_wr[i] !== ex_wr[i] ||
                         lg_addr[i] !== ex_addr[i] || lg_len[i] !== ex_len[i] ||
                         (!ex_desc[i] && lg_idx[i] != ex_idx[i]))) begin
                same = 1'b0;
                $display("FAIL %s request %0d: actual d%0d w%0d a%0h l%0h i%0h expected d%0d w%0d a%0h l%0h i%0h",
                         tag_log, i, lg_desc[i], lg_wr[i], lg_addr[i], lg_len[i], lg_idx[i],
                         ex_desc[i], ex_wr[i], ex_addr[i], ex_len[i], ex_idx[i]);
            end
        end
        tests++;
        if (!same) fails++;
        check(got_ok === ex_ok, tag_ok, "done_ok", got_ok, ex_ok);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin tbl_addr[i] = '0; tbl_ctl[i] = 32'h8000_0002; end
        // table at 0: single final descriptor of 4 bytes
        tbl_addr[0] = 32'h0000_5000; tbl_ctl[0] = 32'h8000_0004;
        // table at 0x200: 16 (upper bits ignored), 6 (bit 0 ignored), 32 final
        tbl_addr[64] = 32'h2000_0000; tbl_ctl[64] = 32'h0003_0011;
        tbl_addr[65] = 32'h2100_0000; tbl_ctl[65] = 32'h0000_0007;
        tbl_addr[66] = 32'h2200_0000; tbl_ctl[66] = 32'h8000_0020;
        // table at 0x300: zero field with bit 0 set means 64 KiB, final
        tbl_addr[96] = 32'h1000_0000; tbl_ctl[96] = 32'h8000_0001;
        // table at 0x800: 2-byte descriptors without an end flag
        for (int i = 256; i < 1024; i++) begin
            tbl_addr[i] = 32'h3000_0000 + 32'(i * 16); tbl_ctl[i] = 32'h0000_0002;
        end
        lg_n = 0;
        m_ptr = '0; m_rlen = 0; m_last = 1'b0; m_raddr = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_req_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
              {mem_req_valid, done}, 0);

        // R1: first go after reset fetches from address 0 without rewind
        tbl_base = 32'h0;
        run(4, 1'b0, "R1", "R7");

        // R3 R4 R5 R7 R8: sweep of byte counts over a three-entry table
        tbl_base = 32'h200;
        for (int b = 0; b <= 60; b++) begin
            do_rewind_arm();
            run(b, logic'(b[0]), (b == 0) ? "R7" : "R4", (b > 54) ? "R5" : "R7");
        end

        // R3: zero length field means 65536 bytes
        tbl_base = 32'h300;
        do_rewind_arm(); run(65536, 1'b1, "R3", "R7");
        do_rewind_arm(); run(70000, 1'b0, "R3", "R5");
        do_rewind_arm(); run(100,   1'b1, "R3", "R7");

        // R6: safeguard after 4 KiB of descriptors
        tbl_base = 32'h800;
        do_rewind_arm(); run(1026, 1'b0, "R6", "R6");
        do_rewind_arm(); run(1024, 1'b1, "R6", "R7");

        // R10: leftover region carries over, arm drops it; R2 rewind
        tbl_base = 32'h200;
        do_rewind_arm(); run(10, 1'b1, "R2", "R7");
        run(4, 1'b1, "R10", "R10");
        do_arm();
        run(4, 1'b0, "R10", "R10");
        run(8, 1'b0, "R10", "R8");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule